// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host talk to external Ethernet PHYs over the two-wire management bus, using a small register port. The host packs a complete Clause 22 transaction into one 32-bit maintenance word and writes it. The controller then clocks out a preamble and the word on MDC/MDIO. While the frame is on the wire, a status bit shows the port busy. When the operation is a read, the controller lets go of MDIO from the turnaround onward. It shifts in the 16 bits the PHY returns and writes them over the low half of the maintenance word, where the host reads them back.

The MDC rate comes from a 3-bit divisor code in a configuration register. The code picks one of eight clock ratios, not all of them powers of two. A control bit enables the port. With the bit clear, MDC stays low and a maintenance write starts nothing. MDC toggles only while a frame is in progress, and the divisor code is latched when each frame starts.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every register reads zero except the status word, which reads 0x0000_0004 (idle). MDC and the MDIO output enable are both low.
- R2: The register port has four word addresses. Address 0 is control, with the port enable at bit 4. Address 1 is configuration, with the divisor code at bits 20:18. Address 2 is status, with idle at bit 2. Address 3 is the maintenance word. Every other bit reads zero.
- R3: A maintenance write accepted at a clock edge clears the idle bit from the next cycle on. It stays clear for exactly 64×D clock cycles and then reads 1, where D is the selected divisor.
- R4: Divisor codes 0 through 7 select D = 8, 16, 32, 48, 64, 96, 128 and 224. During a frame, MDC has a period of D clock cycles and is high for half of it. Between frames MDC is low.
- R5: A frame is 32 bits of ones followed by maintenance bits 31 down to 0, most significant first. Bits 31:30 hold start, 29:28 the operation, 27:23 the PHY address, 22:18 the register number, 17:16 the turnaround and 15:0 the data.
- R6: If bits 29:28 are 10 (read), the controller stops driving MDIO from the turnaround's first bit (bit 17) to the end of the frame, which is 18×D cycles. It samples the 16 data bits on MDC rising edges, most significant first, and loads them into maintenance bits 15:0. Bits 31:16 keep their value.
- R7: For any other operation code, 01 (write) included, MDIO is driven for the whole frame and the maintenance word keeps the value the host wrote.
- R8: The MDIO output level changes only on MDC falling edges, or while MDC is low. It never changes while MDC is high.
- R9: While control bit 4 is clear, a maintenance write still stores the word but starts no frame. MDC stays low and idle stays 1.
- R10: A maintenance write that arrives while a frame is running is dropped. The frame carries on with the original word, and the maintenance word afterwards holds the original upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | ADDR_W | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output level |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input level from the pad |

## Verification
The idle bit falls in the first cycle after the edge that accepts the maintenance write. It rises again exactly 64×D cycles later, and the returned read data is already in the maintenance word in that same cycle. The bench samples at each falling clock edge and counts busy cycles, MDC-high cycles, released-MDIO cycles and the spacing between MDC rising edges. It compares those counts with 64×D, 32×D, 18×D and D, so a result that comes one cycle early or late shows up as a count mismatch. A bench PHY responder captures each bit on the MDC rise. It drives read data after each MDC fall, which lets the bench check the frame contents and the returned data once idle is back.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int WORD_W     = 32;
   localparam int DATA_W     = 16;
   localparam int OP_POS     = 28;
   localparam int TA_POS     = 17;
   localparam int CFG_LSB    = 18;
   localparam int EN_BIT     = 4;
   localparam int IDLE_BIT   = 2;
   localparam int MAX_DIV    = 224;

   localparam int A_CTRL  = 0;
   localparam int A_CFG   = 1;
   localparam int A_STAT  = 2;
   localparam int A_MAINT = 3;

   localparam logic [1:0] MDIO_OP_RD = 2'b10;
   localparam logic [1:0] MDIO_OP_WR = 2'b01;

   function automatic int unsigned mdc_divisor(input int unsigned code);
      case (code)
         0:       return 8;
         1:       return 16;
         2:       return 32;
         3:       return 48;
         4:       return 64;
         5:       return 96;
         6:       return 128;
         default: return 224;
      endcase
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
   import mdio_mgmt_pkg::*;
#(
   parameter int CODE_W = 3,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [CODE_W-1:0] code_in,
   output logic              mdc,
   output logic              rise_tick,
   output logic              fall_tick,
   output logic [CODE_W-1:0] code_q
);
   localparam int N_CODES = 1 << CODE_W;

   if ((1 << CNT_W) < MAX_DIV / 2) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest half period");
   end

   logic [CNT_W-1:0] half_m1 [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_lut
      assign half_m1[g] = CNT_W'(mdc_divisor(g) / 2 - 1);
   end

   logic [CNT_W-1:0] cnt;
   logic             mdc_q;
   logic             term;

   assign term = (cnt == half_m1[code_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         mdc_q  <= 1'b0;
         code_q <= '0;
      end else begin
         if (start) code_q <= code_in;
         if (!run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
         end else if (term) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign mdc       = mdc_q;
   assign rise_tick = run & term & ~mdc_q;
   assign fall_tick = run & term & mdc_q;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int FW      = WORD_W,
   parameter int DW      = DATA_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] word_in,
   input  logic          rise_tick,
   input  logic          fall_tick,
   input  logic          mdio_in,
   output logic          busy,
   output logic          mdio_out,
   output logic          mdio_oe,
   output logic          finish,
   output logic          rd_load,
   output logic [DW-1:0] rd_word
);
   localparam int FRAME_LEN = PRE_LEN + FW;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);
   localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] I_REL  = IDX_W'(PRE_LEN + FW - 1 - TA_POS);
   localparam logic [IDX_W-1:0] I_SMP  = IDX_W'(PRE_LEN + FW - DW);
   localparam logic [IDX_W-1:0] I_LAST = IDX_W'(FRAME_LEN - 1);

   if (DW >= FW - 2 || TA_POS < DW) begin : g_bad_fields
      $error("data field does not fit below the turnaround");
   end

   logic [IDX_W-1:0] idx;
   logic [FW-1:0]    sh;
   logic [DW-1:0]    rd_sh;
   logic             is_rd;
   logic             busy_q;
   logic             last;

   assign last = (idx == I_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= I_LAST;
         sh     <= '0;
         rd_sh  <= '0;
         is_rd  <= 1'b0;
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx    <= '0;
         sh     <= word_in;
         is_rd  <= (word_in[OP_POS +: 2] == MDIO_OP_RD);
      end else if (busy_q) begin
         if (rise_tick && is_rd && idx >= I_SMP)
            rd_sh <= {rd_sh[DW-2:0], mdio_in};
         if (fall_tick) begin
            if (last) begin
               busy_q <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
               if (idx >= I_PRE) sh <= {sh[FW-2:0], 1'b0};
            end
         end
      end
   end

   assign busy     = busy_q;
   assign mdio_out = (idx < I_PRE) ? 1'b1 : sh[FW-1];
   assign mdio_oe  = busy_q & ~(is_rd & (idx >= I_REL));
   assign finish   = busy_q & fall_tick & last;
   assign rd_load  = finish & is_rd;
   assign rd_word  = rd_sh;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int PRE_LEN = 32,
   parameter int CODE_W  = 3,
   parameter int CNT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must reach four registers");
   end
   if (CODE_W != 3) begin : g_bad_code
      $error("divisor table is defined for a 3-bit code");
   end
   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN out of range");
   end

   logic              en_q;
   logic [CODE_W-1:0] cfg_code_q;
   logic [31:0]       maint_q;
   logic              busy;
   logic              wr_maint;
   logic              start;
   logic              rise_tick;
   logic              fall_tick;
   logic              finish;
   logic              rd_load;
   logic [15:0]       rd_word;
   logic [CODE_W-1:0] frame_code;

   assign wr_maint = reg_we && (reg_waddr == ADDR_W'(A_MAINT));
   assign start    = wr_maint && en_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         cfg_code_q <= '0;
         maint_q    <= '0;
      end else begin
         if (reg_we && reg_waddr == ADDR_W'(A_CTRL))
            en_q <= reg_wdata[EN_BIT];
         if (reg_we && reg_waddr == ADDR_W'(A_CFG))
            cfg_code_q <= reg_wdata[CFG_LSB +: CODE_W];
         if (rd_load)
            maint_q[15:0] <= rd_word;
         else if (wr_maint && !busy)
            maint_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         ADDR_W'(A_CTRL):  reg_rdata[EN_BIT] = en_q;
         ADDR_W'(A_CFG):   reg_rdata[CFG_LSB +: CODE_W] = cfg_code_q;
         ADDR_W'(A_STAT):  reg_rdata[IDLE_BIT] = ~busy;
         ADDR_W'(A_MAINT): reg_rdata = maint_q;
         default:          reg_rdata = '0;
      endcase
   end

   mdio_mdc_gen #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .run       (busy),
      .code_in   (cfg_code_q),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .code_q    (frame_code)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .word_in   (reg_wdata),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_in   (mdio_in),
      .busy      (busy),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe),
      .finish    (finish),
      .rd_load   (rd_load),
      .rd_word   (rd_word)
   );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
   import mdio_mgmt_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mdc,
   input logic              mdio_out,
   input logic              mdio_oe,
   input logic              wr_maint,
   input logic              en_q,
   input logic              rd_load,
   input logic [31:0]       maint_q,
   input logic [CODE_W-1:0] frame_code
);
   logic       mdc_d;
   logic [7:0] run_cnt;
   logic [7:0] half_exp;
   logic       toggled;

   assign toggled  = (mdc != mdc_d);
   assign half_exp = 8'(mdc_divisor(int'(frame_code)) / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_d   <= 1'b0;
         run_cnt <= '0;
      end else begin
         mdc_d <= mdc;
         if (!busy)        run_cnt <= '0;
         else if (toggled) run_cnt <= 8'd1;
         else              run_cnt <= run_cnt + 8'd1;
      end
   end

   // R4: each MDC level lasts half of the latched divisor
   p_mdc_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      toggled |-> run_cnt == half_exp);

   // R4: MDC quiet and MDIO released between frames
   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R8: MDIO level holds while MDC is high
   p_mdio_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> $stable(mdio_out));

   // R9: a disabled port does not start on a maintenance write
   p_disabled_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !busy && wr_maint) |=> !busy);

   // R10: a write during a frame leaves the maintenance word alone
   p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_maint && !rd_load) |=> $stable(maint_q));

   // R6: read completion keeps the upper half
   p_read_keeps_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> $stable(maint_q[31:16]));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .mdc        (mdc),
   .mdio_out   (mdio_out),
   .mdio_oe    (mdio_oe),
   .wr_maint   (wr_maint),
   .en_q       (en_q),
   .rd_load    (rd_load),
   .maint_q    (maint_q),
   .frame_code (frame_code)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  waddr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  raddr = '0;
   logic [31:0] rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_line;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   // bench PHY responder
   localparam logic [4:0] RSP_PHY = 5'd3;
   logic [15:0] mem [32];
   int          rsp_cnt = 0;
   logic [63:0] rsp_bits = '0;
   logic [1:0]  rsp_op = '0;
   logic [4:0]  rsp_phy = '0;
   logic [4:0]  rsp_reg = '0;
   logic        rsp_drv = 1'b0;
   logic        rsp_val = 1'b1;

   assign mdio_line = mdio_oe ? mdio_o : (rsp_drv ? rsp_val : 1'b1);

   mdio_mgmt_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (we),
      .reg_waddr (waddr),
      .reg_wdata (wdata),
      .reg_raddr (raddr),
      .reg_rdata (rdata),
      .mdc       (mdc),
      .mdio_out  (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_in   (mdio_line)
   );

   always @(posedge mdc) begin
      logic [63:0] nb;
      nb = {rsp_bits[62:0], mdio_line};
      rsp_bits <= nb;
      rsp_cnt  <= rsp_cnt + 1;
      if (rsp_cnt == 45) begin
         rsp_op  <= nb[11:10];
         rsp_phy <= nb[9:5];
         rsp_reg <= nb[4:0];
      end
      if (rsp_cnt == 63 && rsp_op == 2'b01 && rsp_phy == RSP_PHY)
         mem[rsp_reg] <= nb[15:0];
   end

   always @(negedge mdc) begin
      if (rsp_op == 2'b10 && rsp_phy == RSP_PHY) begin
         if (rsp_cnt == 47) begin
            rsp_drv <= 1'b1; rsp_val <= 1'b0;
         end else if (rsp_cnt >= 48 && rsp_cnt <= 63) begin
            rsp_drv <= 1'b1; rsp_val <= mem[rsp_reg][63 - rsp_cnt];
         end else if (rsp_cnt >= 64) begin
            rsp_drv <= 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; waddr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      raddr = a;
      #1;
      d = rdata;
   endtask

   task automatic run_frame(input logic [31:0] w, output int busy_n, output int hi_n,
                            output int rel_n, output int per, output int cont);
      int r1, r2, t;
      logic pm;
      rsp_cnt = 0; rsp_op = '0; rsp_drv = 1'b0; rsp_bits = '0;
      busy_n = 0; hi_n = 0; rel_n = 0; cont = 0; r1 = -1; r2 = -1; pm = 1'b0; t = 0;
      raddr = 4'd2;
      reg_wr(4'd3, w);
      #1;
      while (rdata[2] == 1'b0 && t < 30000) begin
         busy_n++;
         if (mdc) hi_n++;
         if (!mdio_oe) rel_n++;
         if (mdio_oe && rsp_drv) cont++;
         if (mdc && !pm) begin
            if (r1 < 0) r1 = t;
            else if (r2 < 0) r2 = t;
         end
         pm = mdc;
         t++;
         @(negedge clk);
         #1;
      end
      per = r2 - r1;
   endtask

   function automatic int div_of(input int code);
      case (code)
         0: return 8;   1: return 16;  2: return 32;  3: return 48;
         4: return 64;  5: return 96;  6: return 128; default: return 224;
      endcase
   endfunction

   // code, op, phy, reg, data, expected low half after the frame
   localparam logic [46:0] VECS [0:7] = '{
      {3'd0, 2'b01, 5'd3, 5'd4,  16'h1234, 16'h1234},
      {3'd1, 2'b10, 5'd3, 5'd4,  16'h0000, 16'h1234},
      {3'd2, 2'b10, 5'd3, 5'd9,  16'h0000, 16'hA509},
      {3'd3, 2'b01, 5'd3, 5'd31, 16'hBEEF, 16'hBEEF},
      {3'd4, 2'b10, 5'd3, 5'd31, 16'h5555, 16'hBEEF},
      {3'd5, 2'b10, 5'd7, 5'd2,  16'h0000, 16'hFFFF},
      {3'd6, 2'b01, 5'd3, 5'd0,  16'h0000, 16'h0000},
      {3'd7, 2'b10, 5'd3, 5'd0,  16'hFFFF, 16'h0000}
   };

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] d, w;
      int bn, hn, rn, pr, ct, dv, cnt_a, cnt_b;
      for (int i = 0; i < 32; i++) mem[i] = 16'hA500 ^ 16'(i);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      reg_rd(4'd0, d); check(d == 32'h0, "R1 ctrl", d, 0);
      reg_rd(4'd1, d); check(d == 32'h0, "R1 cfg", d, 0);
      reg_rd(4'd2, d); check(d == 32'h4, "R1 status", d, 4);
      reg_rd(4'd3, d); check(d == 32'h0, "R1 maint", d, 0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);

      // R2: field positions, other bits read zero
      reg_wr(4'd0, 32'hFFFF_FFFF);
      reg_rd(4'd0, d); check(d == 32'h10, "R2 ctrl", d, 32'h10);
      reg_wr(4'd1, 32'hFFFF_FFFF);
      reg_rd(4'd1, d); check(d == 32'h001C_0000, "R2 cfg", d, 32'h001C_0000);
      reg_rd(4'd2, d); check(d == 32'h4, "R2 status", d, 4);

      // table walk: R3 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         logic [2:0]  code;
         logic [1:0]  op;
         logic [4:0]  phy, rg;
         logic [15:0] dat, exp;
         logic [1:0]  ta_exp;
         {code, op, phy, rg, dat, exp} = VECS[v];
         dv = div_of(int'(code));
         reg_wr(4'd1, 32'(code) << 18);
         reg_rd(4'd1, d);
         check(d == (32'(code) << 18), "R2 cfg code", d, 32'(code) << 18);
         w = {2'b01, op, phy, rg, 2'b10, dat};
         run_frame(w, bn, hn, rn, pr, ct);
         check(bn == 64 * dv, "R3 busy cycles", bn, 64 * dv);
         check(pr == dv, "R4 mdc period", pr, dv);
         check(hn == 32 * dv, "R4 mdc high cycles", hn, 32 * dv);
         check(rsp_bits[63:32] == 32'hFFFF_FFFF && rsp_cnt == 64, "R5 preamble", rsp_bits[63:32], 32'hFFFF_FFFF);
         ta_exp = (op == 2'b10 && phy != RSP_PHY) ? 2'b11 : 2'b10;
         check(rsp_bits[31:16] == {w[31:18], ta_exp}, "R5 header", rsp_bits[31:16], {w[31:18], ta_exp});
         if (op == 2'b10) begin
            check(rn == 18 * dv, "R6 release cycles", rn, 18 * dv);
         end else begin
            check(rn == 0, "R7 driven whole frame", rn, 0);
            check(rsp_bits[15:0] == dat, "R7 data on wire", rsp_bits[15:0], dat);
         end
         check(ct == 0, "R6 no contention", ct, 0);
         reg_rd(4'd3, d);
         check(d == {w[31:16], exp}, op == 2'b10 ? "R6 read data" : "R7 maint kept", d, {w[31:16], exp});
      end

      // R9: disabled port
      reg_wr(4'd0, 32'h0);
      rsp_cnt = 0;
      raddr = 4'd2;
      reg_wr(4'd3, 32'h6C12_0000);
      cnt_a = 0; cnt_b = 0;
      for (int k = 0; k < 300; k++) begin
         #1;
         if (mdc) cnt_a++;
         if (rdata[2] == 1'b0) cnt_b++;
         @(negedge clk);
      end
      check(cnt_a == 0 && rsp_cnt == 0, "R9 mdc quiet", cnt_a, 0);
      check(cnt_b == 0, "R9 stays idle", cnt_b, 0);
      reg_rd(4'd3, d); check(d == 32'h6C12_0000, "R9 word stored", d, 32'h6C12_0000);
      reg_wr(4'd0, 32'h10);

      // R10: write during a frame
      reg_wr(4'd1, 32'h0);
      w = {2'b01, 2'b10, 5'd3, 5'd9, 2'b10, 16'h0000};
      rsp_cnt = 0; rsp_op = '0; rsp_drv = 1'b0; rsp_bits = '0;
      raddr = 4'd2;
      reg_wr(4'd3, w);
      repeat (100) @(negedge clk);
      reg_wr(4'd3, 32'h5A5A_5A5A);
      cnt_a = 0;
      #1;
      while (rdata[2] == 1'b0 && cnt_a < 2000) begin
         cnt_a++;
         @(negedge clk);
         #1;
      end
      check(rsp_bits[31:18] == w[31:18], "R10 frame unchanged", rsp_bits[31:18], w[31:18]);
      reg_rd(4'd3, d); check(d == {w[31:16], 16'hA509}, "R10 maint kept", d, {w[31:16], 16'hA509});

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule